// File: doc/BRIEF.md
# Portal Resource Permission Checker

This block sits between the request portals that software uses and a queue manager. Each request names the portal it arrives on, an isolation-context ID that the hardware request path attaches, and a target resource ID. Every portal has a mode bit. When a portal is not isolated, its resource ID is taken as a real ID and goes through unchanged, with no table lookup.

When a portal is isolated, the resource ID is treated as virtual. The block searches a fully associative permissions table for an entry whose context ID and virtual ID both match the request. On a hit, the virtual ID is replaced by the real ID stored in that entry. On a miss, the request is taken from the input and dropped, and an error log records the first offender until software clears it. Because the context ID comes from hardware, software cannot reach a resource that belongs to another partition.

The table entries and the portal mode bits are written through plain write strobes. The lookup result is registered, so a response appears one cycle after the request is accepted. Both the request side and the response side use a valid/ready handshake.

Top module: `prc_portal_guard`

## Requirements
- R1: After reset, rsp_valid and err_flag are 0, req_ready is 1, every table entry is invalid and every portal is non-isolated.
- R2: A request accepted on a non-isolated portal is forwarded with rsp_rid equal to req_vid whatever the table holds, and it never raises an error.
- R3: A request accepted on an isolated portal whose (req_ctx, req_vid) matches a valid entry is forwarded with rsp_rid equal to that entry's real ID.
- R4: The match needs both the context ID and the virtual ID. An entry with the same virtual ID but a different context ID does not match.
- R5: A request on an isolated portal with no matching valid entry is accepted (req_ready stays 1), produces no response, and raises err_flag in the next cycle.
- R6: err_flag, err_ctx and err_vid hold the first blocked request until an err_clr pulse. Later blocks do not overwrite them. If a clear and a block happen in the same cycle, the new block is captured.
- R7: When several valid entries match, the real ID comes from the entry with the lowest index.
- R8: rsp_valid rises in the cycle after acceptance. While rsp_valid is 1 and rsp_ready is 0, the response fields hold steady and req_ready is 0.
- R9: Writing an entry with its valid bit at 0 removes it from lookups. Writing a mode bit changes how later requests on that portal are treated.
- R10: A forwarded response carries the request's context ID and portal index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ent_we | input | 1 | Table entry write strobe |
| cfg_ent_idx | input | EW | Index of the entry to write |
| cfg_ent_vld | input | 1 | Valid bit of the written entry |
| cfg_ent_ctx | input | CTX_W | Context ID of the written entry |
| cfg_ent_vid | input | ID_W | Virtual ID of the written entry |
| cfg_ent_rid | input | ID_W | Real ID of the written entry |
| cfg_mode_we | input | 1 | Portal mode write strobe |
| cfg_mode_port | input | PW | Portal whose mode is written |
| cfg_mode_iso | input | 1 | 1 = isolated, 0 = pass-through |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_port | input | PW | Portal index of the request |
| req_ctx | input | CTX_W | Isolation-context ID from the hardware request path |
| req_vid | input | ID_W | Resource ID as presented by the portal |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_port | output | PW | Portal index of the response |
| rsp_ctx | output | CTX_W | Context ID of the response |
| rsp_rid | output | ID_W | Real resource ID |
| err_clr | input | 1 | Clears the error log |
| err_flag | output | 1 | A blocked request has been logged |
| err_ctx | output | CTX_W | Context ID of the first blocked request |
| err_vid | output | ID_W | Virtual ID of the first blocked request |

## Verification
A corrupt table entry or a wrong priority pick shows up one cycle after acceptance, as a wrong rsp_rid or as a request that is dropped when it should have been forwarded. A wrong portal mode bit shows as an unexpected translation or an unexpected block on the very next request from that portal. A fault in the error log shows as err_ctx or err_vid changing under a second block, or as a failure to capture a block that arrives in the same cycle as a clear. The bench keeps a model of the table, the modes and the log, and compares every response and every log value one cycle after each request, both for random traffic and for the hand-picked corner cases.

// File: rtl/prc_pkg.sv
package prc_pkg;
    localparam int CTX_W = 6;
    localparam int ID_W  = 8;

    typedef logic [CTX_W-1:0] ctx_t;
    typedef logic [ID_W-1:0]  rid_t;

    typedef struct packed {
        logic vld;
        ctx_t ctx;
        rid_t vid;
        rid_t rid;
    } ent_t;

    typedef struct packed {
        ctx_t ctx;
        rid_t vid;
    } key_t;

    typedef struct packed {
        ctx_t ctx;
        rid_t rid;
    } rsp_t;

    function automatic logic ent_match(input ent_t e, input key_t k);
        return e.vld && (e.ctx == k.ctx) && (e.vid == k.vid);
    endfunction
endpackage

// File: rtl/prc_ent_table.sv
module prc_ent_table #(
    parameter int N_ENT = 16,
    localparam int EW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [EW-1:0]       wr_idx,
    input  prc_pkg::ent_t       wr_ent,
    input  prc_pkg::key_t       key,
    output logic [N_ENT-1:0]    hit_vec,
    input  logic [EW-1:0]       rd_idx,
    output prc_pkg::rid_t       rd_rid
);
    prc_pkg::ent_t tbl_q [N_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) tbl_q[i] <= '0;
        end else if (wr_en) begin
            tbl_q[wr_idx] <= wr_ent;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit_vec[g] = prc_pkg::ent_match(tbl_q[g], key);
    end

    assign rd_rid = tbl_q[rd_idx].rid;
endmodule

// File: rtl/prc_low_pick.sv
module prc_low_pick #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/prc_err_log.sv
module prc_err_log (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk,
    input  prc_pkg::ctx_t blk_ctx,
    input  prc_pkg::rid_t blk_vid,
    input  logic          clr,
    output logic          flag,
    output prc_pkg::ctx_t ctx,
    output prc_pkg::rid_t vid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            ctx  <= '0;
            vid  <= '0;
        end else begin
            if (clr) flag <= 1'b0;
            if (blk && (!flag || clr)) begin
                flag <= 1'b1;
                ctx  <= blk_ctx;
                vid  <= blk_vid;
            end
        end
    end
endmodule

// File: rtl/prc_portal_guard.sv
module prc_portal_guard #(
    parameter int N_ENT  = 16,
    parameter int N_PORT = 4,
    localparam int EW = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int PW = (N_PORT > 1) ? $clog2(N_PORT) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_ent_we,
    input  logic [EW-1:0]              cfg_ent_idx,
    input  logic                       cfg_ent_vld,
    input  logic [prc_pkg::CTX_W-1:0]  cfg_ent_ctx,
    input  logic [prc_pkg::ID_W-1:0]   cfg_ent_vid,
    input  logic [prc_pkg::ID_W-1:0]   cfg_ent_rid,
    input  logic                       cfg_mode_we,
    input  logic [PW-1:0]              cfg_mode_port,
    input  logic                       cfg_mode_iso,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [PW-1:0]              req_port,
    input  logic [prc_pkg::CTX_W-1:0]  req_ctx,
    input  logic [prc_pkg::ID_W-1:0]   req_vid,
    output logic                       rsp_valid,
    input  logic                       rsp_ready,
    output logic [PW-1:0]              rsp_port,
    output logic [prc_pkg::CTX_W-1:0]  rsp_ctx,
    output logic [prc_pkg::ID_W-1:0]   rsp_rid,
    input  logic                       err_clr,
    output logic                       err_flag,
    output logic [prc_pkg::CTX_W-1:0]  err_ctx,
    output logic [prc_pkg::ID_W-1:0]   err_vid
);
    import prc_pkg::*;

    logic [N_PORT-1:0] iso_q;
    ent_t              wr_ent;
    key_t              lk_key;
    logic [N_ENT-1:0]  hit_vec;
    logic              lk_hit;
    logic [EW-1:0]     lk_idx;
    rid_t              lk_rid;
    logic              acc, port_iso, blk, fwd;
    logic              rsp_vld_q;
    logic [PW-1:0]     rsp_port_q;
    rsp_t              rsp_q;

    // Portal mode bits: 1 means the portal's IDs are virtual
    always_ff @(posedge clk) begin
        if (rst)              iso_q <= '0;
        else if (cfg_mode_we) iso_q[cfg_mode_port] <= cfg_mode_iso;
    end

    assign wr_ent = '{vld: cfg_ent_vld, ctx: cfg_ent_ctx, vid: cfg_ent_vid, rid: cfg_ent_rid};
    assign lk_key = '{ctx: req_ctx, vid: req_vid};

    prc_ent_table #(.N_ENT(N_ENT)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_ent_we),
        .wr_idx (cfg_ent_idx),
        .wr_ent (wr_ent),
        .key    (lk_key),
        .hit_vec(hit_vec),
        .rd_idx (lk_idx),
        .rd_rid (lk_rid)
    );

    prc_low_pick #(.N(N_ENT)) u_pick (
        .vec(hit_vec),
        .any(lk_hit),
        .idx(lk_idx)
    );

    assign req_ready = !rsp_vld_q || rsp_ready;
    assign acc       = req_valid && req_ready;
    assign port_iso  = iso_q[req_port];
    assign blk       = acc && port_iso && !lk_hit;
    assign fwd       = acc && !(port_iso && !lk_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld_q  <= 1'b0;
            rsp_port_q <= '0;
            rsp_q      <= '0;
        end else if (fwd) begin
            rsp_vld_q  <= 1'b1;
            rsp_port_q <= req_port;
            rsp_q.ctx  <= req_ctx;
            rsp_q.rid  <= port_iso ? lk_rid : req_vid;
        end else if (rsp_ready) begin
            rsp_vld_q  <= 1'b0;
        end
    end

    assign rsp_valid = rsp_vld_q;
    assign rsp_port  = rsp_port_q;
    assign rsp_ctx   = rsp_q.ctx;
    assign rsp_rid   = rsp_q.rid;

    prc_err_log u_err (
        .clk    (clk),
        .rst    (rst),
        .blk    (blk),
        .blk_ctx(req_ctx),
        .blk_vid(req_vid),
        .clr    (err_clr),
        .flag   (err_flag),
        .ctx    (err_ctx),
        .vid    (err_vid)
    );
endmodule

// File: rtl/prc_guard_chk.sv
module prc_guard_chk #(
    parameter int N_PORT = 4,
    parameter int PW = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic [N_PORT-1:0]         iso_q,
    input logic                      lk_hit,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic [PW-1:0]             req_port,
    input logic [prc_pkg::CTX_W-1:0] req_ctx,
    input logic [prc_pkg::ID_W-1:0]  req_vid,
    input logic                      rsp_valid,
    input logic                      rsp_ready,
    input logic [prc_pkg::CTX_W-1:0] rsp_ctx,
    input logic [prc_pkg::ID_W-1:0]  rsp_rid,
    input logic                      err_clr,
    input logic                      err_flag,
    input logic [prc_pkg::CTX_W-1:0] err_ctx,
    input logic [prc_pkg::ID_W-1:0]  err_vid
);
    logic acc, iso_now;
    assign acc     = req_valid && req_ready;
    assign iso_now = iso_q[req_port];

    // R1: the first cycle out of reset is idle and has a clean log
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !err_flag));

    // R2: pass-through keeps the ID
    a_r2_pass: assert property (@(posedge clk) disable iff (rst)
        (acc && !iso_now) |=> (rsp_valid && rsp_rid == $past(req_vid)));

    // R5: a miss on an isolated portal is dropped and logged
    a_r5_block: assert property (@(posedge clk) disable iff (rst)
        (acc && iso_now && !lk_hit) |=> (!rsp_valid && err_flag));

    // R6: the log is sticky until cleared
    a_r6_keep: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> (err_flag && $stable(err_ctx) && $stable(err_vid)));

    // R8: a stalled response holds and blocks new requests
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rid) && $stable(rsp_ctx)));

    a_r8_backpress: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    // R10: the context ID is carried through
    a_r10_ctx: assert property (@(posedge clk) disable iff (rst)
        (acc && !(iso_now && !lk_hit)) |=> (rsp_ctx == $past(req_ctx)));
endmodule

bind prc_portal_guard prc_guard_chk #(.N_PORT(N_PORT), .PW(PW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .iso_q    (iso_q),
    .lk_hit   (lk_hit),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_port (req_port),
    .req_ctx  (req_ctx),
    .req_vid  (req_vid),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_ctx  (rsp_ctx),
    .rsp_rid  (rsp_rid),
    .err_clr  (err_clr),
    .err_flag (err_flag),
    .err_ctx  (err_ctx),
    .err_vid  (err_vid)
);

// File: tb/test_prc_portal_guard.sv
`timescale 1ns/1ps
module test_prc_portal_guard;
    localparam int N_ENT = 16;
    localparam int N_PORT = 4;
    localparam int EW = 4;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_ent_we = 0, cfg_ent_vld = 0, cfg_mode_we = 0, cfg_mode_iso = 0;
    logic [EW-1:0] cfg_ent_idx = '0;
    logic [5:0] cfg_ent_ctx = '0, req_ctx = '0;
    logic [7:0] cfg_ent_vid = '0, cfg_ent_rid = '0, req_vid = '0;
    logic [PW-1:0] cfg_mode_port = '0, req_port = '0;
    logic req_valid = 0, rsp_ready = 1, err_clr = 0;
    logic req_ready, rsp_valid, err_flag;
    logic [PW-1:0] rsp_port;
    logic [5:0] rsp_ctx, err_ctx;
    logic [7:0] rsp_rid, err_vid;

    always #2.5 clk = ~clk;

    prc_portal_guard #(.N_ENT(N_ENT), .N_PORT(N_PORT)) i_prc_portal_guard (.*);

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Bench model
    bit m_vld [N_ENT];
    int m_ctx [N_ENT], m_vid [N_ENT], m_rid [N_ENT];
    bit m_iso [N_PORT];
    bit e_flag = 0;
    int e_ctx = 0, e_vid = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_lookup(input int p, input int c, input int v,
                                         output bit fwd, output int rid);
        fwd = 1; rid = v;
        if (m_iso[p]) begin
            fwd = 0;
            for (int i = N_ENT - 1; i >= 0; i--)
                if (m_vld[i] && m_ctx[i] == c && m_vid[i] == v) begin
                    fwd = 1; rid = m_rid[i];
                end
        end
    endfunction

    task automatic wr_ent(input int idx, input bit vld, input int c, input int v, input int r);
        @(negedge clk);
        cfg_ent_we = 1; cfg_ent_idx = EW'(idx); cfg_ent_vld = vld;
        cfg_ent_ctx = 6'(c); cfg_ent_vid = 8'(v); cfg_ent_rid = 8'(r);
        @(negedge clk);
        cfg_ent_we = 0;
        m_vld[idx] = vld; m_ctx[idx] = c; m_vid[idx] = v; m_rid[idx] = r;
    endtask

    task automatic set_mode(input int p, input bit iso);
        @(negedge clk);
        cfg_mode_we = 1; cfg_mode_port = PW'(p); cfg_mode_iso = iso;
        @(negedge clk);
        cfg_mode_we = 0;
        m_iso[p] = iso;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        e_flag = 0;
        chk(err_flag == 0, "R6", "flag after clear", int'(err_flag), 0);
    endtask

    task automatic send(input int p, input int c, input int v, input bit clr, input string tag);
        bit fwd; int rid;
        @(negedge clk);
        model_lookup(p, c, v, fwd, rid);
        req_valid = 1; req_port = PW'(p); req_ctx = 6'(c); req_vid = 8'(v); err_clr = clr;
        chk(req_ready == 1, tag, "req_ready", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 0; err_clr = 0;
        if (clr) e_flag = 0;
        if (!fwd && !e_flag) begin e_flag = 1; e_ctx = c; e_vid = v; end
        chk(rsp_valid == fwd, tag, "rsp_valid", int'(rsp_valid), int'(fwd));
        if (fwd) begin
            chk(rsp_rid == 8'(rid), tag, "rsp_rid", int'(rsp_rid), rid);
            chk(rsp_ctx == 6'(c) && rsp_port == PW'(p), "R10", "ctx/port", int'({rsp_port, rsp_ctx}), (p << 6) | c);
        end
        chk(err_flag == e_flag, "R6", "err_flag", int'(err_flag), int'(e_flag));
        if (e_flag)
            chk(err_ctx == 6'(e_ctx) && err_vid == 8'(e_vid), "R6", "err ctx/vid",
                int'({err_ctx, err_vid}), (e_ctx << 8) | e_vid);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        for (int i = 0; i < N_ENT; i++) begin m_vld[i] = 0; m_ctx[i] = 0; m_vid[i] = 0; m_rid[i] = 0; end
        for (int i = 0; i < N_PORT; i++) m_iso[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(rsp_valid == 0, "R1", "rsp_valid", int'(rsp_valid), 0);
        chk(err_flag == 0, "R1", "err_flag", int'(err_flag), 0);
        chk(req_ready == 1, "R1", "req_ready", int'(req_ready), 1);
        send(0, 3, 9, 0, "R1");            // portal 0 not isolated after reset
        set_mode(0, 1);
        send(0, 3, 9, 0, "R1");            // no valid entries: blocked
        clear_err();
        // R2: pass-through ignores the table
        wr_ent(1, 1, 2, 8'h55, 8'hA0);
        send(1, 2, 8'h55, 0, "R2");
        // R3: isolated hit
        wr_ent(2, 1, 3, 9, 8'h20);
        send(0, 3, 9, 0, "R3");
        // R4: other context misses
        send(0, 4, 9, 0, "R4");
        // R5/R6: a second miss leaves the log alone
        send(0, 5, 1, 0, "R5");
        clear_err();
        send(0, 6, 2, 0, "R6");
        send(0, 7, 3, 1, "R6");            // clear and block in the same cycle
        clear_err();
        // R7: lowest index wins
        wr_ent(7, 1, 3, 9, 8'h44);
        wr_ent(5, 1, 3, 9, 8'h33);
        send(0, 3, 9, 0, "R7");
        // R9: invalidate entry 2, entry 5 takes over
        wr_ent(2, 0, 3, 9, 8'h20);
        send(0, 3, 9, 0, "R9");
        set_mode(0, 0);
        send(0, 3, 9, 0, "R9");
        // R8: stall
        @(negedge clk);
        rsp_ready = 0; req_valid = 1; req_port = 1; req_ctx = 1; req_vid = 8'h12;
        @(negedge clk);
        chk(rsp_valid == 1 && rsp_rid == 8'h12, "R8", "rsp after 1 cycle", int'(rsp_rid), 8'h12);
        req_vid = 8'h34;
        chk(req_ready == 0, "R8", "req_ready in stall", int'(req_ready), 0);
        repeat (2) begin
            @(negedge clk);
            chk(rsp_valid == 1 && rsp_rid == 8'h12, "R8", "held rid", int'(rsp_rid), 8'h12);
        end
        rsp_ready = 1;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 1 && rsp_rid == 8'h34, "R8", "second rid", int'(rsp_rid), 8'h34);
        @(negedge clk);
        chk(rsp_valid == 0, "R8", "drained", int'(rsp_valid), 0);
        // Random traffic
        for (int k = 0; k < 600; k++) begin
            int sel;
            sel = int'($urandom_range(0, 31));
            if (sel < 4)
                wr_ent(int'($urandom_range(0, N_ENT - 1)), ($urandom_range(0, 3) != 0),
                       int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 255)));
            else if (sel < 6)
                set_mode(int'($urandom_range(0, N_PORT - 1)), $urandom_range(0, 1) == 1);
            else if (sel == 6)
                clear_err();
            else
                send(int'($urandom_range(0, N_PORT - 1)), int'($urandom_range(0, 3)),
                     int'($urandom_range(0, 7)), (sel == 7), "R3");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule